// File: doc/BRIEF.md
# Password-Gated Protection Lock Controller

This block guards a single protection lock bit behind a 64-bit password. The password lives in a register that survives a soft reset and only returns to all ones on a hard reset, so it stands in for nonvolatile storage. Software talks to the block through a command stream. Each command carries an operation code, an address whose low two bits pick one 16-bit quarter of the password, and 16 bits of data. Read results leave on a one-entry response stream.

A session starts with an enter command, which also blocks main-memory access. Inside the session software can do four things. It can program quarters of the password, and programming can only turn ones into zeros. It can read quarters back, until a one-way mode lock masks every read to all ones. It can supply the four unlock quarters in any order. After the last quarter arrives, a timed compare window runs. At the end of the window an exact match releases the protection lock bit.

A malformed unlock cycle traps the block in an abort state until a dedicated abort-reset command arrives.

Top module: `pwlock_ctrl`

## Requirements
- R1: Program (op 3), read (op 4), unlock (op 5), set-mode-lock (op 6) and exit (op 2) act only inside the password set. Enter (op 1) opens the set and exit closes it. `mem_block` is high exactly while the set is open.
- R2: Program ANDs `cmd_data` into the quarter picked by `cmd_addr[1:0]`. Quarter 0 is password bits 15:0 and quarter 3 is bits 63:48. Quarters may be programmed in any order.
- R3: When a program tries to set a bit that is already 0, that bit stays 0 and `pgm_fail` goes high. `pgm_fail` holds its value until the next program command that is carried out, which rewrites it. It also clears on a soft reset.
- R4: Hard reset (`rst_n` low) does the following:
  - sets the password to all ones;
  - clears the mode lock;
  - sets `prot_frozen` to 1;
  - clears session, abort, busy and response state.
- R5: A read returns the selected quarter while the mode lock is clear and 16'hFFFF once it is set. The mode lock can only be undone by a hard reset.
- R6: If any address bit above bit 1 is 1, a program or read command has no effect and a read gives no response.
- R7: The four captured unlock quarters are compared with the stored password at the end of the window. Only an exact 64-bit match drives `prot_frozen` to 0. A mismatch leaves it unchanged.
- R8: `busy` rises in the cycle after the fourth distinct unlock quarter is accepted. It stays high for exactly WIN_CYC = CLK_MHZ*2 cycles. `prot_frozen` changes only at the edge that ends the window.
- R9: An unlock command that arrives while `busy` is high is ignored, whatever its address or data.
- R10: An unlock with a nonzero address bit above bit 1 does three things:
  - sets `aborted`;
  - discards the quarters captured so far;
  - causes every command except abort-reset (op 7) to be ignored.

  Abort-reset clears `aborted`.
- R11: A command transfers when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a response is pending. `rsp_valid` stays high and `rsp_data` stays stable until `rsp_ready` is high at a clock edge.
- R12: Soft reset (`soft_rst`) keeps the password and the mode lock. It closes the set, clears abort, busy, captured quarters, `pgm_fail` and any pending response, and sets `prot_frozen` back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; keeps the password and the mode lock |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready; low while a response is pending |
| cmd_op | input | 3 | Operation: 1 enter, 2 exit, 3 program, 4 read, 5 unlock, 6 set mode lock, 7 abort-reset |
| cmd_addr | input | ADDR_W | Address; bits 1:0 pick the quarter and the upper bits must be zero |
| cmd_data | input | 16 | Program or unlock data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | 16 | Read response data |
| busy | output | 1 | Unlock compare window running |
| prot_frozen | output | 1 | Protection lock bit; 1 means frozen |
| mode_locked | output | 1 | Password mode lock; reads are masked when set |
| mem_block | output | 1 | Main-memory access blocked; the password set is open |
| aborted | output | 1 | Abort state after a bad unlock cycle |
| pgm_fail | output | 1 | Last program command tried to set a 0 bit back to 1 |

## Verification
The bench attacks the following corner cases:

- **Partial captures after an abort.** It supplies three correct quarters after an abort. A design that kept the captures from before the abort would start the window early.
- **Unlock attempts during the window.** It sends a wrong quarter and a bad address while the window runs. A design that let either through would fail the match or drop into abort.
- **Window length.** It measures the busy window to the cycle. An off-by-one counter shows up as a length of 399 or 401 cycles.
- **Resets, lock and back-pressure.** It checks the following:
  - the password survives a soft reset;
  - the mode lock cannot be cleared except by a hard reset;
  - a command offered while a response waits is dropped, not queued;
  - a program that tries to raise a bit to 1 reports failure and leaves the bit at 0.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;
  localparam int SEG_W = 16;
  localparam int NSEG  = 4;
  localparam int SEL_W = $clog2(NSEG);
  localparam int PW_W  = SEG_W * NSEG;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ENTER = 3'd1,
    OP_EXIT  = 3'd2,
    OP_PGM   = 3'd3,
    OP_READ  = 3'd4,
    OP_UNLK  = 3'd5,
    OP_SETLK = 3'd6,
    OP_ABRST = 3'd7
  } pw_op_e;
endpackage

// File: rtl/pw_store.sv
module pw_store
  import pwlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_seg,
  output logic             wr_fail,
  output logic [PW_W-1:0]  pw_flat
);
  logic [SEG_W-1:0] segs [NSEG];

  // Each quarter can only lose ones: new = old AND data.
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        segs[g] <= '1;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        segs[g] <= segs[g] & wr_data;
    end
    assign pw_flat[g*SEG_W +: SEG_W] = segs[g];
  end

  assign rd_seg  = segs[rd_sel];
  // A one in the data over a zero cell is an attempt to raise a bit.
  assign wr_fail = |(wr_data & ~segs[wr_sel]);
endmodule

// File: rtl/unlock_engine.sv
module unlock_engine
  import pwlock_pkg::*;
#(
  parameter int WIN_CYC = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [SEL_W-1:0] sel,
  input  logic [SEG_W-1:0] data,
  input  logic [PW_W-1:0]  pw_flat,
  output logic             busy,
  output logic             done,
  output logic             match
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [SEG_W-1:0] caps [NSEG];
  logic [PW_W-1:0]  cap_flat;
  logic [NSEG-1:0]  mask, nxt_mask;
  logic [CNT_W-1:0] cnt;
  logic             start;

  for (genvar g = 0; g < NSEG; g++) begin : g_flat
    assign cap_flat[g*SEG_W +: SEG_W] = caps[g];
  end

  assign nxt_mask = mask | ({{(NSEG-1){1'b0}}, take} << sel);
  assign start    = take && (&nxt_mask);
  assign done     = busy && (cnt == CNT_W'(1));
  assign match    = (cap_flat == pw_flat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      mask <= '0;
      for (int i = 0; i < NSEG; i++) caps[i] <= '0;
    end else if (clr || done) begin
      busy <= 1'b0;
      cnt  <= '0;
      mask <= '0;
      for (int i = 0; i < NSEG; i++) caps[i] <= '0;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (take) begin
        caps[sel] <= data;
        mask      <= nxt_mask;
      end
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WIN_CYC);
      end
    end
  end
endmodule

// File: rtl/pwlock_ctrl.sv
module pwlock_ctrl
  import pwlock_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_MHZ = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SEG_W-1:0]  cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [SEG_W-1:0]  rsp_data,
  output logic              busy,
  output logic              prot_frozen,
  output logic              mode_locked,
  output logic              mem_block,
  output logic              aborted,
  output logic              pgm_fail
);
  localparam int WIN_CYC = CLK_MHZ * 2;

  pw_op_e           op;
  logic             acc, live, hi_ok;
  logic [SEL_W-1:0] sel;
  logic             enter_go, exit_go, pgm_go, rd_go, unl_cmd, take, bad;
  logic             setlk_go, abrst_go;
  logic [SEG_W-1:0] rd_seg;
  logic             wr_fail, eng_done, eng_match;
  logic [PW_W-1:0]  pw_flat;
  logic             in_set;

  assign op        = pw_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid;
  assign acc       = cmd_valid && cmd_ready;
  assign sel       = cmd_addr[SEL_W-1:0];
  assign hi_ok     = (cmd_addr[ADDR_W-1:SEL_W] == '0);
  assign live      = acc && in_set && !aborted && !soft_rst;

  assign enter_go = acc && !aborted && !soft_rst && (op == OP_ENTER);
  assign abrst_go = acc && aborted && (op == OP_ABRST);
  assign exit_go  = live && (op == OP_EXIT);
  assign pgm_go   = live && (op == OP_PGM) && hi_ok;
  assign rd_go    = live && (op == OP_READ) && hi_ok;
  assign setlk_go = live && (op == OP_SETLK);
  assign unl_cmd  = live && (op == OP_UNLK) && !busy;
  assign take     = unl_cmd && hi_ok;
  assign bad      = unl_cmd && !hi_ok;

  pw_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pgm_go),
    .wr_sel  (sel),
    .wr_data (cmd_data),
    .rd_sel  (sel),
    .rd_seg  (rd_seg),
    .wr_fail (wr_fail),
    .pw_flat (pw_flat)
  );

  unlock_engine #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst || bad),
    .take    (take),
    .sel     (sel),
    .data    (cmd_data),
    .pw_flat (pw_flat),
    .busy    (busy),
    .done    (eng_done),
    .match   (eng_match)
  );

  // Mode lock: one-way, only a hard reset returns it to 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_locked <= 1'b0;
    else if (setlk_go) mode_locked <= 1'b1;
  end

  // Session, abort, lock bit, status and response slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_set      <= 1'b0;
      aborted     <= 1'b0;
      prot_frozen <= 1'b1;
      pgm_fail    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else if (soft_rst) begin
      in_set      <= 1'b0;
      aborted     <= 1'b0;
      prot_frozen <= 1'b1;
      pgm_fail    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      if (enter_go)                   in_set      <= 1'b1;
      else if (exit_go)               in_set      <= 1'b0;
      if (bad)                        aborted     <= 1'b1;
      else if (abrst_go)              aborted     <= 1'b0;
      if (eng_done && eng_match)      prot_frozen <= 1'b0;
      if (pgm_go)                     pgm_fail    <= wr_fail;
      if (rd_go) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mode_locked ? '1 : rd_seg;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign mem_block = in_set;
endmodule

// File: rtl/pwlock_chk.sv
module pwlock_chk
  import pwlock_pkg::*;
#(
  parameter int WIN_CYC = 400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [SEG_W-1:0] rsp_data,
  input logic             busy,
  input logic             prot_frozen,
  input logic             mode_locked,
  input logic             in_set,
  input logic             aborted,
  input logic [PW_W-1:0]  pw_flat
);
  localparam int RW = $clog2(WIN_CYC + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  a_r3_pw_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_flat & ~$past(pw_flat)) == '0);

  a_r5_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> mode_locked);

  a_r5_locked_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && mode_locked) |-> (rsp_data == '1));

  a_r1_busy_inside_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (in_set && !aborted));

  a_r7_unfreeze_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_frozen) |-> ($past(busy) && !busy));

  a_r12_refreeze_only_soft: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_frozen) |-> $past(soft_rst));

  a_r8_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(soft_rst)) |-> (run == RW'(WIN_CYC)));

  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(WIN_CYC));

  a_r10_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (aborted && !soft_rst && !(cmd_valid && cmd_ready && cmd_op == 3'(OP_ABRST)))
      |=> aborted);

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !soft_rst) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind pwlock_ctrl pwlock_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .busy        (busy),
  .prot_frozen (prot_frozen),
  .mode_locked (mode_locked),
  .in_set      (mem_block),
  .aborted     (aborted),
  .pw_flat     (pw_flat)
);

// File: tb/tb_pwlock_ctrl.sv
module tb_pwlock_ctrl;
  localparam int WIN = 200 * 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic        busy, prot_frozen, mode_locked, mem_block, aborted, pgm_fail;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwlock_ctrl #(.ADDR_W(8), .CLK_MHZ(200)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .prot_frozen(prot_frozen), .mode_locked(mode_locked),
    .mem_block(mem_block), .aborted(aborted), .pgm_fail(pgm_fail)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_pw [4];
  logic [15:0] m_cap [4];
  bit [3:0]    m_got;
  bit m_mlock, m_frozen, m_in, m_ab, m_busy, m_fail, m_rv;
  int          m_left;
  logic [15:0] m_rd;

  task automatic m_session_clear();
    m_in = 0; m_ab = 0; m_busy = 0; m_left = 0; m_got = '0; m_fail = 0;
    m_rv = 0; m_frozen = 1; m_rd = '0;
    foreach (m_cap[i]) m_cap[i] = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    bit acc, hi, was_busy, same;
    int s;
    if (!rst_n) begin
      foreach (m_pw[i]) m_pw[i] = 16'hFFFF;
      m_mlock = 0;
      m_session_clear();
    end else if (soft_rst) begin
      m_session_clear();
    end else begin
      acc = cmd_valid && !m_rv;
      hi = (cmd_addr[7:2] == 0);
      s = int'(cmd_addr[1:0]);
      was_busy = m_busy;
      if (m_busy) begin
        if (m_left == 1) begin
          same = 1;
          foreach (m_pw[i]) if (m_pw[i] != m_cap[i]) same = 0;
          if (same) m_frozen = 0;
          m_busy = 0; m_got = '0;
          foreach (m_cap[i]) m_cap[i] = '0;
        end else m_left--;
      end
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        if (m_ab) begin
          if (cmd_op == 3'd7) m_ab = 0;
        end else if (cmd_op == 3'd1) begin
          m_in = 1;
        end else if (m_in) begin
          case (cmd_op)
            3'd2: m_in = 0;
            3'd3: if (hi) begin
                    m_fail = |(cmd_data & ~m_pw[s]);
                    m_pw[s] = m_pw[s] & cmd_data;
                  end
            3'd4: if (hi) begin
                    m_rv = 1;
                    m_rd = m_mlock ? 16'hFFFF : m_pw[s];
                  end
            3'd5: if (!was_busy) begin
                    if (!hi) begin
                      m_ab = 1; m_got = '0;
                      foreach (m_cap[i]) m_cap[i] = '0;
                    end else begin
                      m_cap[s] = cmd_data;
                      m_got[s] = 1'b1;
                      if (m_got == 4'hF) begin m_busy = 1; m_left = WIN; end
                    end
                  end
            3'd6: m_mlock = 1;
            default: ;
          endcase
        end
      end
    end
  end

  // Compare outputs with the model on every clock, away from the edge.
  always @(negedge clk) if (cmp_on) begin
    chk(cmd_ready === !m_rv, "R11 cmd_ready", 64'(cmd_ready), 64'(!m_rv));
    chk(rsp_valid === m_rv, "R11 rsp_valid", 64'(rsp_valid), 64'(m_rv));
    if (m_rv) chk(rsp_data === m_rd, "R5 rsp_data", 64'(rsp_data), 64'(m_rd));
    chk(busy === m_busy, "R8 busy", 64'(busy), 64'(m_busy));
    chk(prot_frozen === m_frozen, "R7 prot_frozen", 64'(prot_frozen), 64'(m_frozen));
    chk(mode_locked === m_mlock, "R5 mode_locked", 64'(mode_locked), 64'(m_mlock));
    chk(mem_block === m_in, "R1 mem_block", 64'(mem_block), 64'(m_in));
    chk(aborted === m_ab, "R10 aborted", 64'(aborted), 64'(m_ab));
    chk(pgm_fail === m_fail, "R3 pgm_fail", 64'(pgm_fail), 64'(m_fail));
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v, output bit got);
    issue(3'd4, a, '0);
    got = rsp_valid;
    v = rsp_data;
    if (got) begin
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] v; bit got;
    rd(a, v, got);
    chk(got, tag, 64'(got), 64'd1);
    chk(v === exp, tag, 64'(v), 64'(exp));
  endtask

  task automatic rd_none(input logic [7:0] a, input string tag);
    logic [15:0] v; bit got;
    rd(a, v, got);
    chk(!got, tag, 64'(got), 64'd0);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic do_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin : main
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk(prot_frozen === 1'b1, "R4 frozen after reset", 64'(prot_frozen), 64'd1);
    chk(mem_block === 1'b0, "R1 set closed after reset", 64'(mem_block), 64'd0);

    // R1: outside the set nothing acts
    issue(3'd3, 8'h00, 16'h0000);
    rd_none(8'h00, "R1 read outside set");
    issue(3'd1, 8'h00, '0);
    chk(mem_block === 1'b1, "R1 enter opens set", 64'(mem_block), 64'd1);
    for (int q = 0; q < 4; q++) rd_expect(8'(q), 16'hFFFF, "R4 default password");

    // R2: program quarters out of order
    issue(3'd3, 8'h02, 16'h1234);
    issue(3'd3, 8'h00, 16'hA5A5);
    issue(3'd3, 8'h03, 16'h0F0F);
    issue(3'd3, 8'h01, 16'hBEEF);
    chk(pgm_fail === 1'b0, "R3 clean program", 64'(pgm_fail), 64'd0);
    rd_expect(8'h00, 16'hA5A5, "R2 quarter0");
    rd_expect(8'h01, 16'hBEEF, "R2 quarter1");
    rd_expect(8'h02, 16'h1234, "R2 quarter2");
    rd_expect(8'h03, 16'h0F0F, "R2 quarter3");

    // R3: try to raise zeros
    issue(3'd3, 8'h00, 16'hFFFF);
    chk(pgm_fail === 1'b1, "R3 raise attempt fails", 64'(pgm_fail), 64'd1);
    rd_expect(8'h00, 16'hA5A5, "R3 bits stay 0");
    issue(3'd3, 8'h00, 16'hA5A5);
    chk(pgm_fail === 1'b0, "R3 status rewritten", 64'(pgm_fail), 64'd0);

    // R6: upper address bits abort program/read
    issue(3'd3, 8'h04, 16'h0000);
    rd_expect(8'h00, 16'hA5A5, "R6 program ignored");
    rd_none(8'h05, "R6 read ignored");

    // R11: back-pressure on the response
    issue(3'd4, 8'h01, '0);
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid === 1'b1, "R11 held valid", 64'(rsp_valid), 64'd1);
      chk(rsp_data === 16'hBEEF, "R11 held data", 64'(rsp_data), 64'hBEEF);
      chk(cmd_ready === 1'b0, "R11 not ready", 64'(cmd_ready), 64'd0);
      if (k == 0) begin
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 8'h01; cmd_data = 16'h0000;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    rd_expect(8'h01, 16'hBEEF, "R11 blocked command dropped");

    // R7/R8: wrong password, window measured
    issue(3'd5, 8'h00, 16'hA5A5);
    issue(3'd5, 8'h01, 16'hBEEF);
    issue(3'd5, 8'h02, 16'h1234);
    chk(busy === 1'b0, "R8 no start before four", 64'(busy), 64'd0);
    issue(3'd5, 8'h03, 16'h0F0E);
    chk(busy === 1'b1, "R8 busy next cycle", 64'(busy), 64'd1);
    wait_idle(n);
    chk(n == WIN, "R8 window length", 64'(n), 64'(WIN));
    chk(prot_frozen === 1'b1, "R7 mismatch keeps frozen", 64'(prot_frozen), 64'd1);

    // R7/R9: correct password, ignored unlocks during the window
    issue(3'd5, 8'h03, 16'h0F0F);
    issue(3'd5, 8'h01, 16'hBEEF);
    issue(3'd5, 8'h00, 16'hA5A5);
    issue(3'd5, 8'h02, 16'h1234);
    issue(3'd5, 8'h00, 16'h0000);
    issue(3'd5, 8'h10, 16'h0000);
    chk(aborted === 1'b0, "R9 bad unlock while busy ignored", 64'(aborted), 64'd0);
    chk(prot_frozen === 1'b1, "R8 no change mid window", 64'(prot_frozen), 64'd1);
    wait_idle(n);
    chk(prot_frozen === 1'b0, "R7 match unfreezes", 64'(prot_frozen), 64'd0);

    // R12: soft reset
    do_soft();
    chk(prot_frozen === 1'b1, "R12 refrozen", 64'(prot_frozen), 64'd1);
    chk(mem_block === 1'b0, "R12 set closed", 64'(mem_block), 64'd0);
    issue(3'd1, 8'h00, '0);
    rd_expect(8'h02, 16'h1234, "R12 password kept");

    // R10: abort trap
    issue(3'd5, 8'h00, 16'hA5A5);
    issue(3'd5, 8'h08, 16'h0000);
    chk(aborted === 1'b1, "R10 abort entered", 64'(aborted), 64'd1);
    issue(3'd3, 8'h03, 16'h0000);
    rd_none(8'h03, "R10 read ignored in abort");
    issue(3'd7, 8'h00, '0);
    chk(aborted === 1'b0, "R10 abort-reset", 64'(aborted), 64'd0);
    rd_expect(8'h03, 16'h0F0F, "R10 program ignored in abort");
    issue(3'd5, 8'h01, 16'hBEEF);
    issue(3'd5, 8'h02, 16'h1234);
    issue(3'd5, 8'h03, 16'h0F0F);
    chk(busy === 1'b0, "R10 captures discarded", 64'(busy), 64'd0);
    issue(3'd5, 8'h00, 16'hA5A5);
    chk(busy === 1'b1, "R10 fourth quarter starts", 64'(busy), 64'd1);
    wait_idle(n);
    chk(prot_frozen === 1'b0, "R7 unlock after abort", 64'(prot_frozen), 64'd0);

    // R5: mode lock masks reads and survives soft reset
    issue(3'd6, 8'h00, '0);
    chk(mode_locked === 1'b1, "R5 lock set", 64'(mode_locked), 64'd1);
    rd_expect(8'h00, 16'hFFFF, "R5 masked read");
    do_soft();
    chk(mode_locked === 1'b1, "R5 lock survives soft reset", 64'(mode_locked), 64'd1);
    issue(3'd1, 8'h00, '0);
    rd_expect(8'h01, 16'hFFFF, "R5 still masked");

    // R1: exit
    issue(3'd2, 8'h00, '0);
    chk(mem_block === 1'b0, "R1 exit closes set", 64'(mem_block), 64'd0);
    rd_none(8'h00, "R1 read after exit");

    // R4: hard reset
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mode_locked === 1'b0, "R4 lock cleared", 64'(mode_locked), 64'd0);
    chk(prot_frozen === 1'b1, "R4 frozen", 64'(prot_frozen), 64'd1);
    issue(3'd1, 8'h00, '0);
    rd_expect(8'h00, 16'hA5A5 | 16'hFFFF, "R4 password all ones");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule